// File: doc/BRIEF.md
# Software-Controlled Loop Buffer

This block is a small instruction store placed next to the normal instruction fetch path. Software installs a short loop body in it by giving a start address, a body length and an iteration count, and then streaming the body words in order. Once the last word has arrived, fetches whose address falls inside the loop window are answered from the store instead of going out to the level-one instruction cache. When the programmed number of iterations has run, the store goes idle and every fetch goes out again.

No tags are kept. A fetch address is turned into an entry index by subtracting the loop start address, so a single block of consecutive words is held. All addresses are word addresses. Fetches that miss are sent on to the external fetch port, and the external responses come back through the same response port. Fetch responses carry a flag that says which source supplied them. The requester keeps at most one fetch outstanding.

Top module: `loop_buf`

## Requirements
- R1: After a synchronous reset the buffer is idle, `fr_valid`, `ext_req_valid` and `cfg_err` are low, and every fetch goes to the external port.
- R2: A configuration with 1 <= `cfg_len` <= DEPTH (32) and `cfg_iters` >= 1 is accepted. The next `cfg_len` cycles with `ld_valid` high store `ld_data` at offsets 0, 1, 2 and so on. The buffer serves fetches only after the last body word has been written, and fetches made while it is filling go external.
- R3: A configuration with `cfg_len` = 0, `cfg_len` > DEPTH or `cfg_iters` = 0, made while `flush` is low, raises `cfg_err` in the following cycle and changes no loop state, so an installed loop keeps being served.
- R4: While a loop is active, a fetch with offset (`fq_addr` - start, unsigned modulo 2^32) below the length is a hit. One cycle later it gives `fr_valid`=1, `fr_hit`=1 and `fr_data` equal to the word stored at that offset, and no external request is made. This also holds when the window crosses address zero.
- R5: A fetch that is not a hit raises `ext_req_valid` one cycle later with `ext_req_addr` = `fq_addr`, and gives no buffer response.
- R6: When `ext_rsp_valid` is high, one cycle later the block gives `fr_valid`=1, `fr_hit`=0 and `fr_data` = `ext_rsp_data`. A buffer hit in the same cycle takes priority.
- R7: Each served fetch of offset length-1 counts one iteration. The fetch that completes the programmed count is still served from the buffer, and later fetches go external.
- R8: `flush` high in cycle t makes every fetch from cycle t+1 on go external, aborts a fill in progress, and overrides a `cfg_valid` in the same cycle.
- R9: `ld_valid` is ignored unless a fill is in progress, and leaves the stored loop body unchanged.
- R10: An accepted configuration while a loop is active replaces that loop at once. Fetches go external until the new body has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate the buffer |
| cfg_valid | input | 1 | Configuration request |
| cfg_start | input | 32 | Loop start word address |
| cfg_len | input | 8 | Body length in words |
| cfg_iters | input | 16 | Iteration count |
| cfg_err | output | 1 | Configuration rejected (one cycle after the request) |
| ld_valid | input | 1 | Body word strobe |
| ld_data | input | 32 | Body word |
| fq_valid | input | 1 | Fetch request |
| fq_addr | input | 32 | Fetch word address |
| fr_valid | output | 1 | Fetch response valid |
| fr_hit | output | 1 | Response came from the buffer |
| fr_data | output | 32 | Response instruction word |
| ext_req_valid | output | 1 | Request to the external fetch path |
| ext_req_addr | output | 32 | External request address |
| ext_rsp_valid | input | 1 | External response valid |
| ext_rsp_data | input | 32 | External response word |

## Verification
Each result has a fixed delay. A hit response, an external request, the forwarding of an external response and `cfg_err` all appear exactly one clock after the input that causes them. Loop state changes made by a flush, a configuration, the last body word or the final iteration take effect for fetches in the next cycle. The bench reference model applies the inputs at each rising edge and predicts the registered outputs for that edge. It compares them with the design at the following falling edge, every cycle, and so checks each result in the single cycle in which it is due.

// File: rtl/loop_buf_pkg.sv
package loop_buf_pkg;
  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_FILL = 2'd1,
    LB_RUN  = 2'd2
  } lb_mode_e;
endpackage

// File: rtl/loop_buf_store.sv
module loop_buf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/loop_buf_ctrl.sv
module loop_buf_ctrl
  import loop_buf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 32,
  parameter int LEN_IN_W = 8,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LEN_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                cfg_valid,
  input  logic [ADDR_W-1:0]   cfg_start,
  input  logic [LEN_IN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0]    cfg_iters,
  input  logic                ld_valid,
  input  logic                fq_valid,
  input  logic [ADDR_W-1:0]   fq_addr,
  output logic                hit,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                we,
  output logic [IDX_W-1:0]    wr_idx,
  output logic                cfg_err
);
  lb_mode_e          mode_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  remain_q;
  logic [IDX_W-1:0]  wptr_q;

  logic              len_ok, accept, in_win, at_last, fill_end;
  logic [ADDR_W-1:0] off;

  assign len_ok   = (cfg_len != '0) && (cfg_len <= LEN_IN_W'(DEPTH)) && (cfg_iters != '0);
  assign accept   = cfg_valid && len_ok;
  // relative index: no tags, only the distance from the loop start
  assign off      = fq_addr - start_q;
  assign in_win   = off < ADDR_W'(len_q);
  assign at_last  = off == ADDR_W'(len_q - LEN_W'(1));
  assign hit      = (mode_q == LB_RUN) && fq_valid && in_win;
  assign rd_idx   = off[IDX_W-1:0];
  assign we       = (mode_q == LB_FILL) && ld_valid && !flush && !accept;
  assign wr_idx   = wptr_q;
  assign fill_end = wptr_q == IDX_W'(len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= LB_IDLE;
      start_q  <= '0;
      len_q    <= '0;
      remain_q <= '0;
      wptr_q   <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_valid && !flush && !len_ok;
      if (flush) begin
        mode_q <= LB_IDLE;
      end else if (accept) begin
        mode_q   <= LB_FILL;
        start_q  <= cfg_start;
        len_q    <= cfg_len[LEN_W-1:0];
        remain_q <= cfg_iters;
        wptr_q   <= '0;
      end else begin
        if (we) begin
          wptr_q <= wptr_q + IDX_W'(1);
          if (fill_end) mode_q <= LB_RUN;
        end
        if (hit && at_last) begin
          if (remain_q == CNT_W'(1)) mode_q <= LB_IDLE;
          else remain_q <= remain_q - CNT_W'(1);
        end
      end
    end
  end

  a_r8_flush_idle: assert property (@(posedge clk) disable iff (rst)
    flush |=> (mode_q == LB_IDLE));
  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !flush && !len_ok) |=> ($stable(start_q) && $stable(len_q)));
  a_r7_remain_live: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_RUN) |-> (remain_q != '0));
  a_r2_fill_ptr: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_FILL) |-> (LEN_W'(wptr_q) < len_q));
endmodule

// File: rtl/loop_buf.sv
module loop_buf #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 32,
  parameter int LEN_IN_W = 8,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                cfg_valid,
  input  logic [ADDR_W-1:0]   cfg_start,
  input  logic [LEN_IN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0]    cfg_iters,
  output logic                cfg_err,
  input  logic                ld_valid,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic                fq_valid,
  input  logic [ADDR_W-1:0]   fq_addr,
  output logic                fr_valid,
  output logic                fr_hit,
  output logic [DATA_W-1:0]   fr_data,
  output logic                ext_req_valid,
  output logic [ADDR_W-1:0]   ext_req_addr,
  input  logic                ext_rsp_valid,
  input  logic [DATA_W-1:0]   ext_rsp_data
);
  logic              hit, we;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [DATA_W-1:0] ram_q, ext_q;

  loop_buf_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LEN_IN_W(LEN_IN_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush),
    .cfg_valid(cfg_valid), .cfg_start(cfg_start), .cfg_len(cfg_len), .cfg_iters(cfg_iters),
    .ld_valid(ld_valid), .fq_valid(fq_valid), .fq_addr(fq_addr),
    .hit(hit), .rd_idx(rd_idx), .we(we), .wr_idx(wr_idx), .cfg_err(cfg_err)
  );

  loop_buf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(wr_idx), .wdata(ld_data),
    .raddr(rd_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_valid      <= 1'b0;
      fr_hit        <= 1'b0;
      ext_q         <= '0;
      ext_req_valid <= 1'b0;
      ext_req_addr  <= '0;
    end else begin
      fr_valid      <= hit || ext_rsp_valid;
      fr_hit        <= hit;
      ext_q         <= ext_rsp_data;
      ext_req_valid <= fq_valid && !hit;
      ext_req_addr  <= fq_addr;
    end
  end

  // source select after the RAM output register
  assign fr_data = fr_hit ? ram_q : ext_q;

  a_r4_hit_no_ext: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && fr_hit) |-> !ext_req_valid);
  a_r5_fetch_answered: assert property (@(posedge clk) disable iff (rst)
    fq_valid |=> ((fr_valid && fr_hit) || ext_req_valid));
endmodule

// File: tb/loop_buf_bench.sv
module loop_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_start = '0;
  logic [7:0]  cfg_len = '0;
  logic [15:0] cfg_iters = '0;
  logic        cfg_err;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_data = '0;
  logic        fq_valid = 1'b0;
  logic [31:0] fq_addr = '0;
  logic        fr_valid, fr_hit;
  logic [31:0] fr_data;
  logic        ext_req_valid;
  logic [31:0] ext_req_addr;
  logic        ext_rsp_valid = 1'b0;
  logic [31:0] ext_rsp_data = '0;

  always #10 clk = ~clk;

  loop_buf u_loop_buf (
    .clk(clk), .rst(rst), .flush(flush),
    .cfg_valid(cfg_valid), .cfg_start(cfg_start), .cfg_len(cfg_len), .cfg_iters(cfg_iters),
    .cfg_err(cfg_err), .ld_valid(ld_valid), .ld_data(ld_data),
    .fq_valid(fq_valid), .fq_addr(fq_addr),
    .fr_valid(fr_valid), .fr_hit(fr_hit), .fr_data(fr_data),
    .ext_req_valid(ext_req_valid), .ext_req_addr(ext_req_addr),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    run_chk = 0;
  string phase = "R1";

  // reference model state
  int          body [32];
  logic [31:0] m_start;
  int          m_len, m_rem, m_mode, m_wp;
  bit          e_fr_v, e_hit, e_ext_v, e_err;
  logic [31:0] e_data, e_ext_a;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_len = 0; m_rem = 0; m_wp = 0; m_start = '0;
      e_fr_v = 0; e_hit = 0; e_ext_v = 0; e_err = 0; e_data = '0; e_ext_a = '0;
    end else begin
      logic [31:0] off;
      bit h, ok;
      off = fq_addr - m_start;
      h   = (m_mode == 2) && fq_valid && (off < 32'(m_len));
      ok  = (cfg_len != 0) && (cfg_len <= 32) && (cfg_iters != 0);
      e_err   = cfg_valid && !flush && !ok;
      e_fr_v  = h || ext_rsp_valid;
      e_hit   = h;
      e_data  = h ? 32'(body[int'(off)]) : ext_rsp_data;
      e_ext_v = fq_valid && !h;
      e_ext_a = fq_addr;
      if (flush) m_mode = 0;
      else if (cfg_valid && ok) begin
        m_mode = 1; m_start = cfg_start; m_len = int'(cfg_len);
        m_rem = int'(cfg_iters); m_wp = 0;
      end else begin
        if (m_mode == 1 && ld_valid) begin
          body[m_wp] = int'(ld_data);
          m_wp++;
          if (m_wp == m_len) m_mode = 2;
        end
        if (h && off == 32'(m_len - 1)) begin
          if (m_rem == 1) m_mode = 0;
          else m_rem--;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s): got %h expected %h", req, phase, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && run_chk) begin
      chk(e_hit ? "R4" : "R6", 32'(fr_valid), 32'(e_fr_v));
      if (e_fr_v) begin
        chk(e_hit ? "R4" : "R6", 32'(fr_hit), 32'(e_hit));
        chk(e_hit ? "R4" : "R6", fr_data, e_data);
      end
      chk("R5", 32'(ext_req_valid), 32'(e_ext_v));
      if (e_ext_v) chk("R5", ext_req_addr, e_ext_a);
      chk("R3", 32'(cfg_err), 32'(e_err));
    end
  end

  // external fetch path: answers one cycle after the request appears
  always @(negedge clk) begin
    ext_rsp_valid <= ext_req_valid;
    ext_rsp_data  <= ~ext_req_addr;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk); fq_valid = 1'b1; fq_addr = a;
    @(negedge clk); fq_valid = 1'b0;
    idle(2);
  endtask

  task automatic config_loop(input logic [31:0] s, input int l, input int it, input bit fl);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_start = s; cfg_len = 8'(l); cfg_iters = 16'(it); flush = fl;
    @(negedge clk); cfg_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic load(input int n, input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ld_valid = 1'b1; ld_data = base + 32'(k * 7);
      if (k % 3 == 1) begin @(negedge clk); ld_valid = 1'b0; end
    end
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic do_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state at the ports
    chk("R1", 32'(fr_valid), 32'd0);
    chk("R1", 32'(ext_req_valid), 32'd0);
    chk("R1", 32'(cfg_err), 32'd0);
    run_chk = 1;
    phase = "R1"; fetch(32'd100);

    phase = "R2";
    config_loop(32'd100, 4, 3, 0);
    fetch(32'd100);
    load(2, 32'hA000_0000);
    fetch(32'd101);
    load(2, 32'hA000_000E);
    idle(2);

    phase = "R4";
    fetch(32'd102); fetch(32'd100); fetch(32'd101); fetch(32'd103);

    phase = "R5";
    fetch(32'd99); fetch(32'd104); fetch(32'd0);

    phase = "R3";
    config_loop(32'd200, 0, 5, 0);
    config_loop(32'd200, 33, 5, 0);
    config_loop(32'd200, 4, 0, 0);
    fetch(32'd101);

    phase = "R9";
    load(3, 32'h5555_0000);
    fetch(32'd100); fetch(32'd102);

    phase = "R7";
    for (int it = 0; it < 3; it++)
      for (int k = 0; k < 4; k++) fetch(32'd100 + 32'(k));
    fetch(32'd100); fetch(32'd103);

    phase = "R8";
    config_loop(32'd500, 8, 10, 0);
    load(8, 32'hB000_0000);
    fetch(32'd503);
    do_flush;
    fetch(32'd503);
    config_loop(32'd500, 8, 10, 0);
    load(3, 32'hB100_0000);
    do_flush;
    load(5, 32'hB200_0000);
    fetch(32'd500);
    config_loop(32'd600, 2, 2, 1);
    load(2, 32'hB300_0000);
    fetch(32'd600);

    phase = "R10";
    config_loop(32'd700, 2, 5, 0);
    load(2, 32'hC000_0000);
    fetch(32'd701);
    config_loop(32'd800, 3, 2, 0);
    fetch(32'd700);
    load(3, 32'hC100_0000);
    fetch(32'd700); fetch(32'd801);

    phase = "R4 wrap";
    config_loop(32'hFFFF_FFF0, 32, 1, 0);
    load(32, 32'hD000_0000);
    fetch(32'hFFFF_FFFF); fetch(32'h0000_0000); fetch(32'hFFFF_FFEF);
    fetch(32'h0000_000F); fetch(32'h0000_0000);

    phase = "R6";
    fetch(32'h1234_5678);
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end
endmodule